// File: doc/BRIEF.md
# Ping-Pong Receive DMA Buffer Manager

This block accepts the received bytes of one serial channel and places them in external memory. It uses two receive buffers that the host supplies, buffer A and buffer B. Each buffer has a descriptor with three registers: a start address, a byte limit and a status byte. Bit 0 of the status byte is an ownership flag. The host fills in a descriptor and sets that flag to hand the buffer to the block. The block then writes frame bytes into the buffer through a byte-wide memory port that has a ready handshake.

When a frame ends, the block hands the buffer back to the host. It clears the ownership flag, writes the real byte count over the limit, and records the end and error flags. A flag tells the host which descriptor the block will take next, and a busy flag shows that a frame is in progress. A frame that does not fit continues in the other buffer if the host owns that buffer to the block. Otherwise the rest of the frame is dropped and the buffer is marked as overrun.

The byte stream comes from an upstream framer. Each byte carries a start-of-frame marker and an end-of-frame marker. The last byte also carries two result flags: one for the end delimiter and one for the CRC check.

Top module: `rxdma_pingpong`

## Requirements
- R1: The register port decodes these addresses: 0 = A start, 1 = A limit/count, 2 = A status, 3 = B start, 4 = B limit/count, 5 = B status, 6 = current write address (read only), 7 = flags (read only). The host can read back what it writes. In each status byte: bit0 = owned by block, bit1 = frame end, bit2 = check error, bit3 = overrun. In the flags register: bit0 = next buffer (0 = A), bit1 = busy.
- R2: The bytes of a frame go to consecutive addresses, starting at the start address of the selected buffer. Register 6 always holds the address of the next byte.
- R3: After reset the next-buffer flag is 0, so buffer A is used first. After each frame the flag points to the buffer that did not receive the frame's last byte.
- R4: The block writes nothing to memory for a frame that begins while the selected buffer's ownership bit is clear. That frame and any byte arriving outside a frame are consumed and discarded, and the flags stay unchanged.
- R5: When the first byte of a frame is accepted, busy is set and the next-buffer flag toggles. A one-byte frame still toggles the flag.
- R6: When the last byte of a frame has been written, busy clears. The status byte of the buffer holding that byte then has ownership cleared and end set. Its error bit is set if either the delimiter flag or the CRC flag reported a failure.
- R7: On frame end, the count register of the buffer holding the last byte is overwritten with the number of frame bytes stored in that buffer.
- R8: When the current buffer already holds as many bytes as its limit and the frame continues, the next byte goes to the other buffer's start address, provided that buffer is owned. The filled buffer then has ownership cleared, its count left equal to its limit, and no end bit. The two buffers may have different limits.
- R9: If the other buffer is not owned at that point, the current buffer's overrun bit is set and its ownership cleared. All remaining bytes of the frame, including the last one, are discarded. Busy clears once the last byte has passed.
- R10: While the memory port is not ready, the byte in flight is held: the input ready output is low. Each byte is written exactly once.
- R11: A synchronous reset clears every ownership bit, busy and the next-buffer flag, and aborts any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is first of frame |
| in_eof | input | 1 | Byte is last of frame |
| in_eof_ok | input | 1 | End delimiter was valid (with last byte) |
| in_crc_ok | input | 1 | CRC check passed (with last byte) |
| in_ready | output | 1 | Byte consumed this cycle |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write address |
| mem_data | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts the write |

## Verification
The bench covers these cases:

- **Chaining** with buffers of unequal limits. A design that checked the wrong limit would switch early or late. One that did not reload the address would write past the end of the filled buffer.
- **Overrun**, where the other buffer is not owned. A wrong design would write into the unowned buffer or keep busy set after the frame ends.
- **Frame start on an unowned buffer.** Any memory write at all would show up.
- **A one-byte frame with a bad delimiter.** This exposes an error bit that looks only at the CRC flag, and a next-buffer flag that toggles only on multi-byte frames.
- **Memory stalls.** A byte that is lost or written twice under a stall shows up as a wrong address or data in a given cycle.
- **Reset in the middle of a frame.** The bench checks that all state is cleared.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
   localparam int ST_OWN    = 0;
   localparam int ST_END    = 1;
   localparam int ST_ERR    = 2;
   localparam int ST_OVR    = 3;
   localparam int ST_BITS   = 4;

   typedef enum logic [2:0] {
      RG_A_START = 3'd0,
      RG_A_LIM   = 3'd1,
      RG_A_STAT  = 3'd2,
      RG_B_START = 3'd3,
      RG_B_LIM   = 3'd4,
      RG_B_STAT  = 3'd5,
      RG_CUR     = 3'd6,
      RG_FLAGS   = 3'd7
   } rg_addr_e;
endpackage

// File: rtl/rxdma_desc.sv
module rxdma_desc #(
   parameter int AW = 32,
   parameter int CW = 16,
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_start,
   input  logic          wr_lim,
   input  logic          wr_stat,
   input  logic [AW-1:0] wdata,
   input  logic          ev_rel,
   input  logic          ev_fin,
   input  logic          ev_ovr,
   input  logic          fin_err,
   input  logic [CW-1:0] fin_cnt,
   output logic [AW-1:0] start,
   output logic [CW-1:0] lim,
   output logic [SW-1:0] stat
);
   import rxdma_pkg::*;

   always_ff @(posedge clk) begin
      if (rst) begin
         start <= '0;
      end else if (wr_start) begin
         start <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lim <= '0;
      end else if (ev_fin) begin
         lim <= fin_cnt;
      end else if (wr_lim) begin
         lim <= wdata[CW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stat <= '0;
      end else if (ev_rel || ev_fin || ev_ovr) begin
         stat[ST_OWN] <= 1'b0;
         if (ev_fin) begin
            stat[ST_END] <= 1'b1;
            stat[ST_ERR] <= fin_err;
         end
         if (ev_ovr) begin
            stat[ST_OVR] <= 1'b1;
         end
      end else if (wr_stat) begin
         stat <= wdata[SW-1:0];
      end
   end
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine #(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [1:0][AW-1:0]  start,
   input  logic [1:0][CW-1:0]  lim,
   input  logic [1:0]          own,
   input  logic                in_valid,
   input  logic [7:0]          in_data,
   input  logic                in_sof,
   input  logic                in_eof,
   input  logic                in_eof_ok,
   input  logic                in_crc_ok,
   output logic                in_ready,
   output logic                mem_valid,
   output logic [AW-1:0]       mem_addr,
   output logic [7:0]          mem_data,
   input  logic                mem_ready,
   output logic [1:0]          ev_rel,
   output logic [1:0]          ev_fin,
   output logic [1:0]          ev_ovr,
   output logic                fin_err,
   output logic [CW-1:0]       fin_cnt,
   output logic                busy,
   output logic                nxt,
   output logic [AW-1:0]       cur_addr
);
   logic          cur;
   logic          drop;
   logic [CW-1:0] cnt;
   logic          need_sw;
   logic          tgt;
   logic [AW-1:0] waddr;
   logic [CW-1:0] wcnt;
   logic          can_wr;
   logic          fire;
   logic          ovr_ev;

   always_comb begin
      need_sw = busy && (cnt == lim[cur]);
      if (!busy) begin
         tgt   = nxt;
         waddr = start[nxt];
         wcnt  = '0;
      end else if (need_sw) begin
         tgt   = !cur;
         waddr = start[!cur];
         wcnt  = '0;
      end else begin
         tgt   = cur;
         waddr = cur_addr;
         wcnt  = cnt;
      end
      can_wr    = in_valid && !drop && own[tgt] && (busy || in_sof);
      fire      = can_wr && mem_ready;
      ovr_ev    = in_valid && busy && !drop && need_sw && !own[!cur];
      mem_valid = can_wr;
      mem_addr  = waddr;
      mem_data  = in_data;
      in_ready  = can_wr ? mem_ready : 1'b1;
      ev_rel    = (fire && need_sw) ? (2'b01 << cur) : 2'b00;
      ev_fin    = (fire && in_eof) ? (2'b01 << tgt) : 2'b00;
      ev_ovr    = ovr_ev ? (2'b01 << cur) : 2'b00;
      fin_cnt   = wcnt + 1'b1;
      fin_err   = !(in_eof_ok && in_crc_ok);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy     <= 1'b0;
         nxt      <= 1'b0;
         cur      <= 1'b0;
         drop     <= 1'b0;
         cnt      <= '0;
         cur_addr <= '0;
      end else if (fire) begin
         busy     <= !in_eof;
         cur      <= tgt;
         nxt      <= !tgt;
         cur_addr <= waddr + 1'b1;
         cnt      <= wcnt + 1'b1;
      end else if (ovr_ev) begin
         drop <= !in_eof;
         busy <= !in_eof;
      end else if (drop && in_valid && in_eof) begin
         drop <= 1'b0;
         busy <= 1'b0;
      end
   end
endmodule

// File: rtl/rxdma_pingpong.sv
module rxdma_pingpong #(
   parameter int AW = 32,
   parameter int CW = 16,
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          reg_wr,
   input  logic [2:0]    reg_addr,
   input  logic [AW-1:0] reg_wdata,
   output logic [AW-1:0] reg_rdata,
   input  logic          in_valid,
   input  logic [7:0]    in_data,
   input  logic          in_sof,
   input  logic          in_eof,
   input  logic          in_eof_ok,
   input  logic          in_crc_ok,
   output logic          in_ready,
   output logic          mem_valid,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_data,
   input  logic          mem_ready
);
   import rxdma_pkg::*;

   localparam int NBUF = 2;
   localparam int REGS_PER_BUF = 3;

   if (SW < ST_BITS) begin : g_bad_sw
      $error("status width too small for flag bits");
   end
   if (CW > AW || SW > AW) begin : g_bad_cw
      $error("count and status must fit the register port");
   end

   logic [NBUF-1:0][AW-1:0] start;
   logic [NBUF-1:0][CW-1:0] lim;
   logic [NBUF-1:0][SW-1:0] stat;
   logic [NBUF-1:0]         own;
   logic [NBUF-1:0]         ev_rel;
   logic [NBUF-1:0]         ev_fin;
   logic [NBUF-1:0]         ev_ovr;
   logic                    fin_err;
   logic [CW-1:0]           fin_cnt;
   logic                    busy;
   logic                    nxt;
   logic [AW-1:0]           cur_addr;

   for (genvar i = 0; i < NBUF; i++) begin : g_desc
      localparam logic [2:0] BASE = 3'(i * REGS_PER_BUF);
      rxdma_desc #(.AW(AW), .CW(CW), .SW(SW)) u_desc (
         .clk      (clk),
         .rst      (rst),
         .wr_start (reg_wr && reg_addr == BASE),
         .wr_lim   (reg_wr && reg_addr == BASE + 3'd1),
         .wr_stat  (reg_wr && reg_addr == BASE + 3'd2),
         .wdata    (reg_wdata),
         .ev_rel   (ev_rel[i]),
         .ev_fin   (ev_fin[i]),
         .ev_ovr   (ev_ovr[i]),
         .fin_err  (fin_err),
         .fin_cnt  (fin_cnt),
         .start    (start[i]),
         .lim      (lim[i]),
         .stat     (stat[i])
      );
      assign own[i] = stat[i][ST_OWN];
   end

   rxdma_engine #(.AW(AW), .CW(CW)) u_eng (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .lim       (lim),
      .own       (own),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_sof    (in_sof),
      .in_eof    (in_eof),
      .in_eof_ok (in_eof_ok),
      .in_crc_ok (in_crc_ok),
      .in_ready  (in_ready),
      .mem_valid (mem_valid),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .mem_ready (mem_ready),
      .ev_rel    (ev_rel),
      .ev_fin    (ev_fin),
      .ev_ovr    (ev_ovr),
      .fin_err   (fin_err),
      .fin_cnt   (fin_cnt),
      .busy      (busy),
      .nxt       (nxt),
      .cur_addr  (cur_addr)
   );

   always_comb begin
      reg_rdata = '0;
      case (rg_addr_e'(reg_addr))
         RG_A_START: reg_rdata = start[0];
         RG_A_LIM:   reg_rdata[CW-1:0] = lim[0];
         RG_A_STAT:  reg_rdata[SW-1:0] = stat[0];
         RG_B_START: reg_rdata = start[1];
         RG_B_LIM:   reg_rdata[CW-1:0] = lim[1];
         RG_B_STAT:  reg_rdata[SW-1:0] = stat[1];
         RG_CUR:     reg_rdata = cur_addr;
         RG_FLAGS:   reg_rdata[1:0] = {busy, nxt};
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rxdma_pingpong_chk.sv
module rxdma_pingpong_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic          in_ready,
   input logic          in_eof,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic          busy,
   input logic          nxt,
   input logic [AW-1:0] cur_addr,
   input logic [1:0]    own
);
   AST_WRITE_OWNED: assert property (@(posedge clk) disable iff (rst)
      mem_valid |-> (|own)); // R4

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
      (mem_valid && mem_ready && !in_eof) |=> (cur_addr == $past(mem_addr) + 1'b1)); // R2

   AST_START_FLIPS: assert property (@(posedge clk) disable iff (rst)
      (!busy && mem_valid && mem_ready && !in_eof) |=> (busy && nxt != $past(nxt))); // R5

   AST_EOF_IDLE: assert property (@(posedge clk) disable iff (rst)
      (mem_valid && mem_ready && in_eof) |=> !busy); // R6

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mem_valid && !mem_ready) |-> !in_ready); // R10
endmodule

bind rxdma_pingpong rxdma_pingpong_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_eof    (in_eof),
   .mem_valid (mem_valid),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .busy      (busy),
   .nxt       (nxt),
   .cur_addr  (cur_addr),
   .own       (own)
);

// File: tb/rxdma_pingpong_tb.sv
`timescale 1ns/1ps
module rxdma_pingpong_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_sof = 1'b0;
   logic        in_eof = 1'b0;
   logic        in_eof_ok = 1'b1;
   logic        in_crc_ok = 1'b1;
   logic        in_ready;
   logic        mem_valid;
   logic [31:0] mem_addr;
   logic [7:0]  mem_data;
   logic        mem_ready = 1'b1;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   bit acc;

   // reference model state
   logic [31:0] m_start [2];
   int          m_lim [2];
   bit          m_own [2];
   bit          m_busy, m_nxt, m_cur, m_drop;
   int          m_cnt;
   logic [31:0] m_addr;

   always #2.5 clk = ~clk;

   rxdma_pingpong u_dut (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
      .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
      .in_eof_ok(in_eof_ok), .in_crc_ok(in_crc_ok), .in_ready(in_ready),
      .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
      .mem_ready(mem_ready)
   );

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 2; i++) begin
         m_start[i] = '0; m_lim[i] = 0; m_own[i] = 0;
      end
      m_busy = 0; m_nxt = 0; m_cur = 0; m_drop = 0; m_cnt = 0; m_addr = '0;
   endtask

   // one clock: compare outputs against model, then advance the model
   task automatic step();
      bit nsw, ev, er, ovr;
      int tb, wc;
      logic [31:0] ea;
      #1;
      nsw = m_busy && (m_cnt == m_lim[m_cur]);
      if (!m_busy) begin tb = m_nxt; ea = m_start[m_nxt]; wc = 0; end
      else if (nsw) begin tb = 1 - m_cur; ea = m_start[tb]; wc = 0; end
      else begin tb = m_cur; ea = m_addr; wc = m_cnt; end
      ev  = !rst && in_valid && !m_drop && m_own[tb] && (m_busy || in_sof);
      er  = ev ? mem_ready : 1'b1;
      ovr = !rst && in_valid && m_busy && !m_drop && nsw && !m_own[1 - m_cur];
      if (!rst) begin
         check(mem_valid === ev, "R4 write request", 32'(mem_valid), 32'(ev));
         check(in_ready === er, "R10 input ready", 32'(in_ready), 32'(er));
         if (ev) begin
            check(mem_addr === ea, "R2 write address", mem_addr, ea);
            check(mem_data === in_data, "R10 write data", 32'(mem_data), 32'(in_data));
         end
      end
      acc = in_valid && in_ready;
      @(posedge clk);
      cyc++;
      if (rst) begin
         model_reset();
      end else begin
         if (ev && mem_ready) begin
            if (nsw) m_own[m_cur] = 0;
            if (in_eof) begin m_own[tb] = 0; m_lim[tb] = wc + 1; end
            m_busy = !in_eof; m_cur = tb[0]; m_nxt = !tb[0];
            m_addr = ea + 1; m_cnt = wc + 1;
         end else if (ovr) begin
            m_own[m_cur] = 0; m_drop = !in_eof; m_busy = !in_eof;
         end else if (m_drop && in_valid && in_eof) begin
            m_drop = 0; m_busy = 0;
         end
         if (reg_wr) begin
            case (reg_addr)
               3'd0: m_start[0] = reg_wdata;
               3'd1: m_lim[0]   = reg_wdata[15:0];
               3'd2: m_own[0]   = reg_wdata[0];
               3'd3: m_start[1] = reg_wdata;
               3'd4: m_lim[1]   = reg_wdata[15:0];
               3'd5: m_own[1]   = reg_wdata[0];
               default: ;
            endcase
         end
      end
      @(negedge clk);
   endtask

   task automatic host_wr(logic [2:0] a, logic [31:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 0;
   endtask

   task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
      reg_addr = a;
      #0.5;
      check(reg_rdata === exp, tag, reg_rdata, exp);
   endtask

   // send n bytes; stall_mod>0 drops mem_ready every stall_mod-th cycle
   task automatic send_frame(int n, logic [7:0] base, bit eok, bit cok,
                             int stall_mod, int mid_flags, bit noeof);
      for (int k = 0; k < n; k++) begin
         in_valid = 1; in_data = base + 8'(k);
         in_sof = (k == 0); in_eof = (k == n - 1) && !noeof;
         in_eof_ok = eok; in_crc_ok = cok;
         do begin
            mem_ready = (stall_mod == 0) || (cyc % stall_mod != 0);
            step();
         end while (!acc && cyc < 150000);
         if (k == 0 && mid_flags >= 0 && n > 1)
            rd_chk(3'd7, 32'(mid_flags), "R5 flags after first byte");
      end
      in_valid = 0; in_sof = 0; in_eof = 0; mem_ready = 1;
      step();
   endtask

   initial begin
      #100000;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      model_reset();
      @(negedge clk);
      step(); step();
      rst = 0;
      // R11 reset state
      rd_chk(3'd7, 32'h0, "R11 flags after reset");
      rd_chk(3'd2, 32'h0, "R11 A status after reset");
      rd_chk(3'd5, 32'h0, "R11 B status after reset");
      rd_chk(3'd6, 32'h0, "R1 current address after reset");

      // single frame into A, with memory stalls
      host_wr(3'd0, 32'h1000); host_wr(3'd1, 32'd8); host_wr(3'd2, 32'h1);
      rd_chk(3'd0, 32'h1000, "R1 A start readback");
      rd_chk(3'd2, 32'h1, "R1 A status readback");
      send_frame(5, 8'h10, 1, 1, 3, 3, 0);
      rd_chk(3'd1, 32'd5, "R7 A count");
      rd_chk(3'd2, 32'h2, "R6 A status end");
      rd_chk(3'd7, 32'h1, "R3 next is B");
      rd_chk(3'd6, 32'h1005, "R2 current address");

      // B not owned: frame discarded; stray byte without start too
      in_valid = 1; in_data = 8'h77; step(); in_valid = 0;
      send_frame(4, 8'h20, 1, 1, 0, -1, 0);
      rd_chk(3'd7, 32'h1, "R4 flags unchanged");
      rd_chk(3'd6, 32'h1005, "R4 address unchanged");

      // chaining B(3) -> A(10), CRC bad
      host_wr(3'd3, 32'h2000); host_wr(3'd4, 32'd3); host_wr(3'd5, 32'h1);
      host_wr(3'd0, 32'h3000); host_wr(3'd1, 32'd10); host_wr(3'd2, 32'h1);
      send_frame(7, 8'h30, 1, 0, 0, 2, 0);
      rd_chk(3'd4, 32'd3, "R8 B count kept at limit");
      rd_chk(3'd5, 32'h0, "R8 B released without end");
      rd_chk(3'd1, 32'd4, "R7 A count after chain");
      rd_chk(3'd2, 32'h6, "R6 A status end and error");
      rd_chk(3'd6, 32'h3004, "R2 address after chain");
      rd_chk(3'd7, 32'h1, "R3 next is B after chain");

      // overrun: B(2) owned, A not owned
      host_wr(3'd3, 32'h4000); host_wr(3'd4, 32'd2); host_wr(3'd5, 32'h1);
      send_frame(5, 8'h40, 1, 1, 2, 2, 0);
      rd_chk(3'd5, 32'h8, "R9 B overrun status");
      rd_chk(3'd4, 32'd2, "R9 B count");
      rd_chk(3'd7, 32'h0, "R9 busy cleared after frame");
      rd_chk(3'd6, 32'h4002, "R9 no write after overrun");

      // one-byte frame with bad delimiter into A
      host_wr(3'd0, 32'h5000); host_wr(3'd1, 32'd4); host_wr(3'd2, 32'h1);
      send_frame(1, 8'h50, 0, 1, 0, -1, 0);
      rd_chk(3'd2, 32'h6, "R6 delimiter error flagged");
      rd_chk(3'd1, 32'd1, "R7 one-byte count");
      rd_chk(3'd7, 32'h1, "R5 next toggles on one-byte frame");

      // reset in the middle of a frame into B
      host_wr(3'd3, 32'h6000); host_wr(3'd4, 32'd4); host_wr(3'd5, 32'h1);
      send_frame(2, 8'h60, 1, 1, 0, 2, 1);
      rd_chk(3'd7, 32'h2, "R5 busy mid frame");
      rst = 1; step(); rst = 0;
      rd_chk(3'd7, 32'h0, "R11 flags after mid-frame reset");
      rd_chk(3'd5, 32'h0, "R11 B status after mid-frame reset");
      step();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule